// File: doc/BRIEF.md
# CAN Transceiver Mode and Fault Controller

This block is the digital control layer that sits between a CAN protocol controller and the analog high-speed CAN driver and receiver. It takes the controller's transmit bit and turns it into a drive-dominant command for the analog driver. It also passes the bus bit from the receiver back to the controller. Two configuration bits select one of three operating modes: full operation, listen-only, or off. A device-mode input blocks both paths whenever the device is in a low-power state.

The block guards the bus against two faults. The first is a supply under-voltage, reported by an external comparator. While it lasts, the block forces the driver recessive and holds the receive output high. The second is a transmit bit stuck low. A counter measures each dominant stretch, and a stretch that lasts too long blocks the driver. Three status bits are available to software. The first follows the comparator live. The second latches any under-voltage seen while the transceiver is enabled. The third latches a dominant timeout. A read-and-clear strobe clears both latched bits.

Top module: `cantx_ctrl`

## Requirements
- R1: With `cfg_en`=0 the mode is off: `drv_dom`=0 and `rxd_out`=1. With `cfg_en`=1 and `cfg_listen`=0 the mode is full: `drv_dom` equals NOT `txd_in` and `rxd_out` equals `bus_rx`, in the same cycle. A low `txd_in` means dominant, and `drv_dom`=1 means drive dominant.
- R2: With `cfg_en`=1 and `cfg_listen`=1 the mode is listen-only: `rxd_out` follows `bus_rx`, while `drv_dom` stays 0 whatever `txd_in` is.
- R3: `st_uv_live` equals `uv_cmp` in the same cycle and holds no memory.
- R4: `st_uv_fail` goes to 1 at the clock edge that samples `uv_cmp`=1 while `cfg_en`=1 and `dev_normal`=1, and it stays at 1 after `uv_cmp` returns to 0. An under-voltage seen while `cfg_en`=0 leaves the bit at 0.
- R5: While `uv_cmp`=1 with `cfg_en`=1, `drv_dom`=0 and `rxd_out`=1 whatever `txd_in` and `bus_rx` are.
- R6: In full mode, when `txd_in` is sampled low at TO_CYCLES consecutive edges, `st_tx_timeout` becomes 1 at the last of those edges and `drv_dom` drops to 0. A high sample on `txd_in` restarts the count.
- R7: While `st_tx_timeout`=1, `drv_dom` stays 0 even after new falling edges on `txd_in`. A `rd_clr` pulse clears `st_tx_timeout` and `st_uv_fail` at the next edge, and transmission resumes after that.
- R8: With `dev_normal`=0, `drv_dom`=0 and `rxd_out`=1 in every mode.
- R9: If `rd_clr` coincides with a new set condition for a latched bit, that bit stays 1.
- R10: After synchronous reset, `st_uv_fail`=0 and `st_tx_timeout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Transceiver enable configuration bit |
| cfg_listen | input | 1 | Listen-only configuration bit |
| dev_normal | input | 1 | 1 = device in normal mode, 0 = low-power |
| uv_cmp | input | 1 | Supply under-voltage comparator, 1 = under-voltage |
| txd_in | input | 1 | Transmit bit from protocol controller, 0 = dominant |
| bus_rx | input | 1 | Bus bit from analog receiver, 0 = dominant |
| rd_clr | input | 1 | Read-and-clear strobe for latched status |
| drv_dom | output | 1 | Drive-dominant command to analog driver |
| rxd_out | output | 1 | Receive bit to protocol controller |
| st_uv_live | output | 1 | Live under-voltage status |
| st_uv_fail | output | 1 | Latched under-voltage status |
| st_tx_timeout | output | 1 | Latched dominant-timeout status |

## Verification
The path outputs `drv_dom` and `rxd_out`, and the live status bit, are combinational. The bench changes inputs one time unit after a rising edge and samples these outputs one time unit later, before the next edge. The latched bits and the blocking they cause appear at the first edge that samples their cause. The bench therefore counts edges exactly: for a timeout it checks the flag still low after TO_CYCLES-1 low samples and high after the TO_CYCLES-th. A latched bit is always read one time unit after the edge that should set or clear it.

// File: rtl/cantx_pkg.sv
package cantx_pkg;

    typedef enum logic [1:0] {
        OPM_OFF    = 2'd0,
        OPM_FULL   = 2'd1,
        OPM_LISTEN = 2'd2
    } opmode_e;

    typedef struct packed {
        logic tx_ok;
        logic rx_ok;
    } path_t;

    function automatic opmode_e decode_mode(input logic en, input logic listen);
        if (!en)        return OPM_OFF;
        else if (listen) return OPM_LISTEN;
        else             return OPM_FULL;
    endfunction

endpackage

// File: rtl/cantx_mode_dec.sv
module cantx_mode_dec
    import cantx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_en,
    input  logic  cfg_listen,
    input  logic  dev_normal,
    input  logic  uv_cmp,
    output path_t path
);
    opmode_e mode;

    always_comb begin
        mode       = decode_mode(cfg_en, cfg_listen);
        path.rx_ok = dev_normal && !uv_cmp && (mode != OPM_OFF);
        path.tx_ok = dev_normal && !uv_cmp && (mode == OPM_FULL);
    end

    // R2: listen-only never grants the transmit path
    p_listen_no_tx_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_listen) |-> !path.tx_ok);
    // R8: low-power blocks both paths
    p_lowpower_block_r8: assert property (@(posedge clk) disable iff (rst)
        !dev_normal |-> (!path.tx_ok && !path.rx_ok));
endmodule

// File: rtl/cantx_dom_timer.sv
module cantx_dom_timer #(
    parameter int TO_CYCLES = 65000
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_ok,
    input  logic txd_in,
    input  logic clr,
    output logic timeout
);
    localparam int CNT_W = $clog2(TO_CYCLES) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             hit;

    assign hit = tx_ok && !txd_in && !timeout && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!tx_ok || txd_in || timeout || hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    cantx_sticky u_to_flag (
        .clk (clk),
        .rst (rst),
        .set (hit),
        .clr (clr),
        .q   (timeout)
    );

    // R6: counter never passes the limit
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    // R7: while blocked the counter stays idle
    p_blocked_idle_r7: assert property (@(posedge clk) disable iff (rst)
        timeout |=> (cnt == '0));
endmodule

// File: rtl/cantx_sticky.sv
module cantx_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set || (q && !clr);
    end

    // R9: a set wins over a coincident clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set |=> q);
    // R7: a clear without a set empties the bit
    p_clr_empties_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q);
endmodule

// File: rtl/cantx_ctrl.sv
module cantx_ctrl
    import cantx_pkg::*;
#(
    parameter int TO_CYCLES = 65000
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_en,
    input  logic cfg_listen,
    input  logic dev_normal,
    input  logic uv_cmp,
    input  logic txd_in,
    input  logic bus_rx,
    input  logic rd_clr,
    output logic drv_dom,
    output logic rxd_out,
    output logic st_uv_live,
    output logic st_uv_fail,
    output logic st_tx_timeout
);
    path_t path;
    logic  uv_event;

    cantx_mode_dec u_dec (
        .clk        (clk),
        .rst        (rst),
        .cfg_en     (cfg_en),
        .cfg_listen (cfg_listen),
        .dev_normal (dev_normal),
        .uv_cmp     (uv_cmp),
        .path       (path)
    );

    cantx_dom_timer #(.TO_CYCLES(TO_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tx_ok   (path.tx_ok),
        .txd_in  (txd_in),
        .clr     (rd_clr),
        .timeout (st_tx_timeout)
    );

    assign uv_event = uv_cmp && cfg_en && dev_normal;

    cantx_sticky u_uv_flag (
        .clk (clk),
        .rst (rst),
        .set (uv_event),
        .clr (rd_clr),
        .q   (st_uv_fail)
    );

    assign drv_dom    = path.tx_ok && !st_tx_timeout && !txd_in;
    assign rxd_out    = path.rx_ok ? bus_rx : 1'b1;
    assign st_uv_live = uv_cmp;

    // R5: under-voltage with enable forces recessive and idle-high receive
    p_uv_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (uv_cmp && cfg_en) |-> (!drv_dom && rxd_out));
    // R7: timeout flag blocks the driver
    p_to_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        st_tx_timeout |-> !drv_dom);
    // R4: enabled under-voltage is latched
    p_uv_latch_r4: assert property (@(posedge clk) disable iff (rst)
        (uv_cmp && cfg_en && dev_normal) |=> st_uv_fail);
    // R1: off mode keeps both paths idle
    p_off_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |-> (!drv_dom && rxd_out));
endmodule

// File: tb/cantx_ctrl_test.sv
module cantx_ctrl_test;
    localparam int TO = 8;

    logic clk = 1'b0;
    logic rst, cfg_en, cfg_listen, dev_normal, uv_cmp, txd_in, bus_rx, rd_clr;
    logic drv_dom, rxd_out, st_uv_live, st_uv_fail, st_tx_timeout;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cantx_ctrl #(.TO_CYCLES(TO)) uut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_listen(cfg_listen),
        .dev_normal(dev_normal), .uv_cmp(uv_cmp), .txd_in(txd_in),
        .bus_rx(bus_rx), .rd_clr(rd_clr), .drv_dom(drv_dom), .rxd_out(rxd_out),
        .st_uv_live(st_uv_live), .st_uv_fail(st_uv_fail),
        .st_tx_timeout(st_tx_timeout)
    );

    // vector: en, listen, normal, uv, txd, bus, exp_drv, exp_rxd
    localparam int NV = 12;
    localparam logic [7:0] VEC [NV] = '{
        8'b1_0_1_0_0_0_1_0,  // R1 full, dominant both ways
        8'b1_0_1_0_1_1_0_1,  // R1 full, recessive
        8'b1_0_1_0_1_0_0_0,  // R1 full, bus dominant from others
        8'b0_0_1_0_0_0_0_1,  // R1 off
        8'b0_1_1_0_0_0_0_1,  // R1 off ignores listen bit
        8'b1_1_1_0_0_0_0_0,  // R2 listen, txd ignored, rx follows
        8'b1_1_1_0_0_1_0_1,  // R2 listen, rx follows high
        8'b1_0_1_1_0_0_0_1,  // R5 under-voltage full
        8'b1_1_1_1_0_0_0_1,  // R5 under-voltage listen
        8'b1_0_0_0_0_0_0_1,  // R8 low-power full
        8'b1_1_0_0_1_0_0_1,  // R8 low-power listen
        8'b0_0_0_0_0_0_0_1   // R8 low-power off
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_full();
        cfg_en = 1; cfg_listen = 0; dev_normal = 1; uv_cmp = 0;
        txd_in = 1; bus_rx = 1; rd_clr = 0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_full();
        rst = 1;
        edge1(); edge1();
        rst = 0;
        #1;
        chk("R10 uv_fail", st_uv_fail, 1'b0);
        chk("R10 timeout", st_tx_timeout, 1'b0);

        for (int i = 0; i < NV; i++) begin
            edge1();
            {cfg_en, cfg_listen, dev_normal, uv_cmp, txd_in, bus_rx} = VEC[i][7:2];
            #1;
            chk("R1/R2/R5/R8 drv", drv_dom, VEC[i][1]);
            chk("R1/R2/R5/R8 rxd", rxd_out, VEC[i][0]);
        end

        // clear anything latched by the table
        edge1(); idle_full(); rd_clr = 1;
        edge1(); rd_clr = 0;
        chk("R7 clear", st_uv_fail, 1'b0);

        // R3 live bit, no memory
        cfg_en = 0; uv_cmp = 1; #1;
        chk("R3 live set", st_uv_live, 1'b1);
        edge1();
        chk("R4 disabled no latch", st_uv_fail, 1'b0);
        uv_cmp = 0; #1;
        chk("R3 live clear", st_uv_live, 1'b0);

        // R4 latching
        cfg_en = 1; uv_cmp = 1; #1;
        chk("R4 before edge", st_uv_fail, 1'b0);
        edge1();
        chk("R4 latched", st_uv_fail, 1'b1);
        uv_cmp = 0;
        edge1();
        chk("R4 held", st_uv_fail, 1'b1);
        // R9 clear coinciding with new under-voltage
        uv_cmp = 1; rd_clr = 1;
        edge1();
        chk("R9 uv set wins", st_uv_fail, 1'b1);
        uv_cmp = 0;
        edge1(); rd_clr = 0;
        chk("R7 uv cleared", st_uv_fail, 1'b0);

        // R6 timeout
        txd_in = 0; #1;
        chk("R6 drv on", drv_dom, 1'b1);
        for (int k = 0; k < TO - 1; k++) edge1();
        chk("R6 not yet", st_tx_timeout, 1'b0);
        chk("R6 drv still", drv_dom, 1'b1);
        edge1();
        chk("R6 timed out", st_tx_timeout, 1'b1);
        chk("R6 drv off", drv_dom, 1'b0);
        // R7 new falling edge stays blocked
        txd_in = 1; edge1(); txd_in = 0; #1;
        chk("R7 still blocked", drv_dom, 1'b0);
        edge1();
        chk("R7 flag held", st_tx_timeout, 1'b1);
        txd_in = 1; rd_clr = 1;
        edge1(); rd_clr = 0;
        chk("R7 flag cleared", st_tx_timeout, 1'b0);
        txd_in = 0; #1;
        chk("R7 resumed", drv_dom, 1'b1);

        // R6 restart on high sample
        txd_in = 1; edge1();
        txd_in = 0;
        for (int k = 0; k < TO - 2; k++) edge1();
        txd_in = 1; edge1();
        txd_in = 0;
        for (int k = 0; k < TO - 2; k++) edge1();
        chk("R6 restart no timeout", st_tx_timeout, 1'b0);
        chk("R6 restart drv", drv_dom, 1'b1);

        // R9 clear coinciding with timeout hit
        txd_in = 1; edge1(); txd_in = 0;
        for (int k = 0; k < TO - 1; k++) edge1();
        rd_clr = 1;
        edge1(); rd_clr = 0;
        chk("R9 timeout set wins", st_tx_timeout, 1'b1);

        // R10 reset clears latches
        uv_cmp = 1; edge1(); uv_cmp = 0;
        rst = 1; edge1(); rst = 0; #1;
        chk("R10 reset uv", st_uv_fail, 1'b0);
        chk("R10 reset to", st_tx_timeout, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule